// File: doc/BRIEF.md
# One-Time-Programmable Security Fuse Bank Controller

This block holds a one-time-programmable security fuse bank in flops: a 256-bit key field, a 32-bit user field and a 14-bit control field. Every bit begins at zero, and a program command can only raise bits. Program commands arrive on a configuration port. Each command carries a 2-bit opcode, a key operand and a 32-bit word operand. One cycle later the controller reports either done or error.

Reads come in on two paths. The debug path returns one 32-bit word per request, one cycle later, chosen by a word address. The fabric path is a continuous copy of the user field. The lock-bearing control bits gate later writes and debug reads. They act only through a shadow lock register, and that register is loaded only by the power-on-reset event input. The ordinary synchronous reset clears the response registers but leaves fuses and locks alone.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After start-up all fuse fields read 0. An accepted program command ORs its operand into the target field, so a bit at 1 stays 1 and a 0 in the operand changes nothing.
- R2: Once control bit 2 is active, opcode 0 and opcode 1 are rejected and leave the key and user fields unchanged. Opcode 2 is still accepted.
- R3: Once control bit 3 is active, a debug read of any key word (addresses 0 to 7) returns 32'hFFFFFFFF. Opcodes 0 and 1 are rejected.
- R4: Once control bit 4 is active, a debug read of the user word (address 8) returns 32'hFFFFFFFF and opcodes 0 and 1 are rejected. `fab_user` still shows the true user field.
- R5: Once control bit 5 is active, opcode 2 is rejected and the control field is unchanged.
- R6: Control bits act only after a `por_event` pulse copies the control field into the lock register. Programming a control bit changes no gating before that pulse. A low `rst_n` clears neither the fuses nor the active locks.
- R7: Opcode 0 ORs the key operand into the key field and word operand bits [7:0] into user bits [7:0]. Opcode 1 ORs word operand bits [31:8] into user bits [31:8] and leaves user bits [7:0] unchanged.
- R8: Opcode 2 ORs word operand bits [13:0] into the control field. Control bits 0, 6, 7, 11, 12 and 13 are reserved: they are never set and always read 0.
- R9: In the cycle after a command, exactly one of `prog_done` (accepted) and `prog_err` (rejected) is high for one cycle. Opcode 3 is always rejected.
- R10: A debug read returns data with `dbg_rd_valid` in the cycle after the request. The address map is: addresses 0 to 7 give key bits [32a+31:32a]; address 8 gives the user field; address 9 gives the control field zero-extended; addresses 10 to 15 give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the response registers |
| por_event | input | 1 | Power-on-reset event; loads the lock register from the control field |
| prog_valid | input | 1 | Program command strobe |
| prog_cmd | input | 2 | Opcode: 0 key and user low byte, 1 user high bits, 2 control, 3 invalid |
| prog_key | input | 256 | Key operand for opcode 0 |
| prog_word | input | 32 | Word operand for the user field or the control field |
| prog_done | output | 1 | One-cycle pulse when a command is accepted |
| prog_err | output | 1 | One-cycle pulse when a command is rejected |
| dbg_rd_req | input | 1 | Debug read request |
| dbg_rd_addr | input | 4 | Debug word address |
| dbg_rd_valid | output | 1 | Debug read data valid |
| dbg_rd_data | output | 32 | Debug read data |
| fab_user | output | 32 | Fabric-path copy of the user field |

## Verification
The bench programs control bits 2, 4, 3 and 5 one at a time, each followed by a power-on event. This order lets every lock be seen alone before the control field is frozen. A design that activates locks when they are programmed would reject the write made just after control bit 2 is set. A design whose ordinary reset clears locks would accept a key write after that reset.

Every debug address is swept after each phase. This catches a key word that is not masked to all ones, a user word that is masked together with the fabric copy, and a reserved bit that reads back as one. A clear attempt and a split user-field write show whether a design overwrites fuses instead of ORing them, and whether opcode 1 disturbs the low byte.

// File: rtl/otp_pkg.sv
// Shared opcodes and lock layout for the fuse bank controller.
// Assumes a 14-bit control field with lock bits at positions 2..5.
package otp_pkg;
    typedef enum logic [1:0] {
        CMD_KEY_LOW   = 2'd0,
        CMD_USER_HIGH = 2'd1,
        CMD_CTRL      = 2'd2,
        CMD_NONE      = 2'd3
    } otp_cmd_e;

    localparam int LK_KEYUSER_WR = 2;
    localparam int LK_KEY_RD     = 3;
    localparam int LK_USER_RD    = 4;
    localparam int LK_CTRL_WR    = 5;

    typedef struct packed {
        logic ctrl_wr;
        logic user_rd;
        logic key_rd;
        logic keyuser_wr;
    } otp_lock_t;
endpackage

// File: rtl/otp_write_gate.sv
// Decides whether a program command is accepted and forms next fuse values.
// Purely combinational; assumes the lock inputs come from the latched shadow.
module otp_write_gate
    import otp_pkg::*;
#(
    parameter int KEY_W  = 256,
    parameter int USER_W = 32,
    parameter int CTRL_W = 14,
    parameter int LOW_W  = 8,
    parameter logic [CTRL_W-1:0] RSVD = 14'h38C1
) (
    input  logic              req,
    input  otp_cmd_e          cmd,
    input  logic [KEY_W-1:0]  key_in,
    input  logic [USER_W-1:0] word_in,
    input  logic              blk_keyuser,
    input  logic              blk_ctrl,
    input  logic [KEY_W-1:0]  key_q,
    input  logic [USER_W-1:0] user_q,
    input  logic [CTRL_W-1:0] ctrl_q,
    output logic              accept,
    output logic              reject,
    output logic [KEY_W-1:0]  key_d,
    output logic [USER_W-1:0] user_d,
    output logic [CTRL_W-1:0] ctrl_d
);
    localparam logic [USER_W-1:0] LOW_MASK = {{(USER_W-LOW_W){1'b0}}, {LOW_W{1'b1}}};

    // Command decode with OR-only merge into the present fuse values.
    always_comb begin
        accept = 1'b0;
        key_d  = key_q;
        user_d = user_q;
        ctrl_d = ctrl_q;
        if (req) begin
            case (cmd)
                CMD_KEY_LOW: if (!blk_keyuser) begin
                    accept = 1'b1;
                    key_d  = key_q | key_in;
                    user_d = user_q | (word_in & LOW_MASK);
                end
                CMD_USER_HIGH: if (!blk_keyuser) begin
                    accept = 1'b1;
                    user_d = user_q | (word_in & ~LOW_MASK);
                end
                CMD_CTRL: if (!blk_ctrl) begin
                    accept = 1'b1;
                    ctrl_d = ctrl_q | (word_in[CTRL_W-1:0] & ~RSVD);
                end
                default: ;
            endcase
        end
        reject = req & ~accept;
    end
endmodule

// File: rtl/otp_fuse_store.sv
// Fuse flops and the shadow lock register.
// Assumes fuses power up at zero and are never cleared; rst_n does not touch them.
module otp_fuse_store
    import otp_pkg::*;
#(
    parameter int KEY_W  = 256,
    parameter int USER_W = 32,
    parameter int CTRL_W = 14,
    parameter logic [CTRL_W-1:0] RSVD = 14'h38C1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              por_event,
    input  logic [KEY_W-1:0]  key_d,
    input  logic [USER_W-1:0] user_d,
    input  logic [CTRL_W-1:0] ctrl_d,
    output logic [KEY_W-1:0]  key_q,
    output logic [USER_W-1:0] user_q,
    output logic [CTRL_W-1:0] ctrl_q,
    output otp_lock_t         lock_q
);
    logic [KEY_W-1:0]  key_r  = '0;
    logic [USER_W-1:0] user_r = '0;
    logic [CTRL_W-1:0] ctrl_r = '0;
    otp_lock_t         lock_r = '0;

    // Fuse update on an accepted command.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            key_r  <= key_d;
            user_r <= user_d;
            ctrl_r <= ctrl_d;
        end
    end

    // Lock shadow loads only on the power-on event.
    always_ff @(posedge clk) begin
        if (por_event) begin
            lock_r.keyuser_wr <= ctrl_r[LK_KEYUSER_WR];
            lock_r.key_rd     <= ctrl_r[LK_KEY_RD];
            lock_r.user_rd    <= ctrl_r[LK_USER_RD];
            lock_r.ctrl_wr    <= ctrl_r[LK_CTRL_WR];
        end
    end

    assign key_q  = key_r;
    assign user_q = user_r;
    assign ctrl_q = ctrl_r;
    assign lock_q = lock_r;

    assert_monotonic_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(key_r) & ~key_r) == '0) && (($past(user_r) & ~user_r) == '0)
         && (($past(ctrl_r) & ~ctrl_r) == '0)));

    assert_lock_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !por_event |=> $stable(lock_r));

    always_comb assert_rsvd_zero_R8: assert ((ctrl_r & RSVD) == '0);
endmodule

// File: rtl/otp_read_port.sv
// Registered debug read port with key and user masking.
// Assumes the user word width equals the read word width.
module otp_read_port #(
    parameter int KEY_W  = 256,
    parameter int WORD_W = 32,
    parameter int CTRL_W = 14,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [KEY_W-1:0]  key_q,
    input  logic [WORD_W-1:0] user_q,
    input  logic [CTRL_W-1:0] ctrl_q,
    input  logic              hide_key,
    input  logic              hide_user,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data
);
    localparam int KEY_WORDS = KEY_W / WORD_W;
    localparam logic [ADDR_W-1:0] A_USER = ADDR_W'(KEY_WORDS);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(KEY_WORDS + 1);

    logic [WORD_W-1:0] sel_data;

    // Address decode with read masking.
    always_comb begin
        sel_data = '0;
        if (rd_addr < A_USER)
            sel_data = hide_key ? '1 : key_q[rd_addr*WORD_W +: WORD_W];
        else if (rd_addr == A_USER)
            sel_data = hide_user ? '1 : user_q;
        else if (rd_addr == A_CTRL)
            sel_data = {{(WORD_W-CTRL_W){1'b0}}, ctrl_q};
    end

    // Response register, cleared by the normal reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            rd_data  <= rd_req ? sel_data : '0;
        end
    end

    assert_rd_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    assert_key_hidden_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_addr < A_USER && hide_key) |=> (rd_data == '1));

    assert_user_hidden_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_addr == A_USER && hide_user) |=> (rd_data == '1));
endmodule

// File: rtl/otp_fuse_ctrl.sv
// Top of the fuse bank controller: write gate, fuse store and debug read port.
// Assumes por_event is a single-cycle pulse; rst_n clears responses only.
module otp_fuse_ctrl
    import otp_pkg::*;
#(
    parameter int KEY_W  = 256,
    parameter int USER_W = 32,
    parameter int CTRL_W = 14,
    parameter int LOW_W  = 8,
    parameter logic [CTRL_W-1:0] RSVD = 14'h38C1,
    localparam int ADDR_W = $clog2(KEY_W / USER_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_event,
    input  logic              prog_valid,
    input  logic [1:0]        prog_cmd,
    input  logic [KEY_W-1:0]  prog_key,
    input  logic [USER_W-1:0] prog_word,
    output logic              prog_done,
    output logic              prog_err,
    input  logic              dbg_rd_req,
    input  logic [ADDR_W-1:0] dbg_rd_addr,
    output logic              dbg_rd_valid,
    output logic [USER_W-1:0] dbg_rd_data,
    output logic [USER_W-1:0] fab_user
);
    logic [KEY_W-1:0]  key_q, key_d;
    logic [USER_W-1:0] user_q, user_d;
    logic [CTRL_W-1:0] ctrl_q, ctrl_d;
    otp_lock_t         lock_q;
    logic              accept, reject, blk_keyuser;

    // Any of three lock bits freezes key and user fields.
    assign blk_keyuser = lock_q.keyuser_wr | lock_q.key_rd | lock_q.user_rd;

    otp_write_gate #(.KEY_W(KEY_W), .USER_W(USER_W), .CTRL_W(CTRL_W),
                     .LOW_W(LOW_W), .RSVD(RSVD)) gate_i (
        .req(prog_valid), .cmd(otp_cmd_e'(prog_cmd)), .key_in(prog_key),
        .word_in(prog_word), .blk_keyuser(blk_keyuser), .blk_ctrl(lock_q.ctrl_wr),
        .key_q(key_q), .user_q(user_q), .ctrl_q(ctrl_q),
        .accept(accept), .reject(reject),
        .key_d(key_d), .user_d(user_d), .ctrl_d(ctrl_d));

    otp_fuse_store #(.KEY_W(KEY_W), .USER_W(USER_W), .CTRL_W(CTRL_W),
                     .RSVD(RSVD)) store_i (
        .clk(clk), .rst_n(rst_n), .wr_en(accept), .por_event(por_event),
        .key_d(key_d), .user_d(user_d), .ctrl_d(ctrl_d),
        .key_q(key_q), .user_q(user_q), .ctrl_q(ctrl_q), .lock_q(lock_q));

    otp_read_port #(.KEY_W(KEY_W), .WORD_W(USER_W), .CTRL_W(CTRL_W),
                    .ADDR_W(ADDR_W)) rd_i (
        .clk(clk), .rst_n(rst_n), .rd_req(dbg_rd_req), .rd_addr(dbg_rd_addr),
        .key_q(key_q), .user_q(user_q), .ctrl_q(ctrl_q),
        .hide_key(lock_q.key_rd), .hide_user(lock_q.user_rd),
        .rd_valid(dbg_rd_valid), .rd_data(dbg_rd_data));

    // One-cycle command response pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_done <= 1'b0;
            prog_err  <= 1'b0;
        end else begin
            prog_done <= accept;
            prog_err  <= reject;
        end
    end

    assign fab_user = user_q;

    assert_blocked_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> ($stable(key_q) && $stable(user_q) && $stable(ctrl_q) && prog_err));

    assert_resp_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_done && prog_err));

    assert_resp_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        prog_valid |=> (prog_done || prog_err));
endmodule

// File: tb/otp_fuse_ctrl_tb.sv
module otp_fuse_ctrl_tb_top;
    localparam logic [13:0] VALID_CTRL = 14'h073E;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         por_event = 1'b0;
    logic         prog_valid = 1'b0;
    logic [1:0]   prog_cmd = '0;
    logic [255:0] prog_key = '0;
    logic [31:0]  prog_word = '0;
    logic         prog_done, prog_err;
    logic         dbg_rd_req = 1'b0;
    logic [3:0]   dbg_rd_addr = '0;
    logic         dbg_rd_valid;
    logic [31:0]  dbg_rd_data, fab_user;

    logic [255:0] mkey  = '0;
    logic [31:0]  muser = '0;
    logic [13:0]  mctrl = '0;
    logic [13:0]  mlock = '0;
    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    otp_fuse_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .por_event(por_event),
        .prog_valid(prog_valid), .prog_cmd(prog_cmd), .prog_key(prog_key),
        .prog_word(prog_word), .prog_done(prog_done), .prog_err(prog_err),
        .dbg_rd_req(dbg_rd_req), .dbg_rd_addr(dbg_rd_addr),
        .dbg_rd_valid(dbg_rd_valid), .dbg_rd_data(dbg_rd_data), .fab_user(fab_user));

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(int a);
        if (a < 8)  return mlock[3] ? 32'hFFFFFFFF : mkey[a*32 +: 32];
        if (a == 8) return mlock[4] ? 32'hFFFFFFFF : muser;
        if (a == 9) return {18'b0, mctrl};
        return 32'h0;
    endfunction

    function automatic logic [255:0] pat(logic [31:0] seed);
        logic [255:0] p;
        for (int i = 0; i < 8; i++) p[i*32 +: 32] = seed ^ (32'h01010101 * (i + 1)) ^ (seed << i);
        return p;
    endfunction

    task automatic prog(string req, logic [1:0] cmd, logic [255:0] k, logic [31:0] w);
        bit blocked;
        if (cmd == 2'd3)      blocked = 1;
        else if (cmd == 2'd2) blocked = mlock[5];
        else                  blocked = mlock[2] | mlock[3] | mlock[4];
        @(negedge clk);
        prog_valid = 1'b1; prog_cmd = cmd; prog_key = k; prog_word = w;
        @(negedge clk);
        prog_valid = 1'b0;
        check({req, " done"}, {31'b0, prog_done}, {31'b0, !blocked});
        check({req, " err"},  {31'b0, prog_err},  {31'b0, blocked});
        if (!blocked) begin
            if (cmd == 2'd0) begin mkey |= k; muser[7:0] |= w[7:0]; end
            if (cmd == 2'd1) muser[31:8] |= w[31:8];
            if (cmd == 2'd2) mctrl |= w[13:0] & VALID_CTRL;
        end
    endtask

    task automatic read_all(string req);
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            dbg_rd_req = 1'b1; dbg_rd_addr = 4'(a);
            @(negedge clk);
            dbg_rd_req = 1'b0;
            check({req, " valid"}, {31'b0, dbg_rd_valid}, 32'd1);
            check({req, $sformatf(" addr %0d", a)}, dbg_rd_data, exp_rd(a));
        end
        check({req, " fab_user"}, fab_user, muser);
    endtask

    task automatic por();
        @(negedge clk); por_event = 1'b1;
        @(negedge clk); por_event = 1'b0;
        mlock = mctrl;
    endtask

    task automatic nrst(string req);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check({req, " rst done"}, {31'b0, prog_done}, 32'd0);
        check({req, " rst err"}, {31'b0, prog_err}, 32'd0);
        check({req, " rst valid"}, {31'b0, dbg_rd_valid}, 32'd0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R1: start-up state
        check("R1 done", {31'b0, prog_done}, 32'd0);
        check("R1 err", {31'b0, prog_err}, 32'd0);
        read_all("R1");
        // R7: key plus user low byte together
        prog("R7", 2'd0, pat(32'hA5A50F0F), 32'h123456A5);
        read_all("R7");
        check("R7 low byte only", fab_user, 32'h000000A5);
        // R1: OR merge and clear attempt
        prog("R1", 2'd0, pat(32'h0F0F3C3C), 32'h0000005A);
        read_all("R1");
        prog("R1 clear", 2'd0, 256'h0, 32'h0);
        read_all("R1");
        // R7: user high bits only
        prog("R7", 2'd1, pat(32'hFFFFFFFF), 32'h80F00F33);
        read_all("R7");
        // R9: invalid opcode
        prog("R9", 2'd3, pat(32'h1), 32'hFFFFFFFF);
        // R8: reserved control bits ignored
        prog("R8", 2'd2, 256'h0, 32'h000038C1);
        read_all("R8");
        // R6: lock programmed but not yet active, normal reset in between
        prog("R6", 2'd2, 256'h0, 32'h00000106);
        nrst("R6");
        prog("R6", 2'd0, pat(32'h00C0FFEE), 32'h00000003);
        read_all("R6");
        // R2: key/user write lock active
        por();
        prog("R2", 2'd0, pat(32'h12345678), 32'h00000010);
        prog("R2", 2'd1, 256'h0, 32'h7F000000);
        prog("R2", 2'd2, 256'h0, 32'h00000010);
        read_all("R2");
        nrst("R6");
        prog("R6", 2'd0, pat(32'h87654321), 32'h00000040);
        // R4: user debug read hidden, fabric copy intact
        por();
        read_all("R4");
        check("R4 fabric", fab_user, muser);
        // R3: key debug read hidden
        prog("R3", 2'd2, 256'h0, 32'h00000008);
        por();
        read_all("R3");
        // R5: control write lock
        prog("R5", 2'd2, 256'h0, 32'h00000020);
        read_all("R5");
        por();
        prog("R5", 2'd2, 256'h0, 32'h00000200);
        read_all("R5");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule